// File: doc/BRIEF.md
# Video-Driven Load Current Predictor

This block estimates the load current a display power converter is about to deliver. It uses only control information already present in the digital video path, so the converter needs no current sensor. At each fast sample strobe the block forms a discharge estimate from two inputs:

- a 1-bit sustain-phase flag, which shows when the panel is in a discharge phase;
- an 8-bit average picture level.

The estimate equals the level while the flag is high and zero otherwise. It is produced by gating, with no multiplier.

The estimate then passes through a programmable second-order low-pass filter that models the LC network between the converter and the panel drivers. The filter output is the predicted load current. It becomes available ahead of the actual load change, because the video data leads the discharge by a fixed delay. A feed-forward stage downstream reads the prediction. A second strobe, one per switching period, latches the prediction so that this stage sees a value that stays constant for the whole period.

The sample strobe must come fast enough to resolve sustain pulses of several hundred kilohertz, which is much faster than the switching period. The five filter coefficients are signed fixed-point inputs. They come from configuration registers elsewhere and are held steady during operation.

Top module: `vid_load_predictor`

## Requirements
- R1: While `rst_n` is low, `pred_now`, `pred_held` and `pred_vld` are zero and the filter history (two past inputs, two past outputs) is cleared. After reset is released, the first sample is computed as if every earlier input and output were zero.
- R2: On a sample strobe the filter input x is `avg_level` (unsigned, 0..255) when `seq_on` is 1, and 0 when `seq_on` is 0.
- R3: On a sample strobe the new output is y = floor((b0*x + b1*x1 + b2*x2 - a1*y1 - a2*y2) / 2^14). Here x1 and x2 are the inputs of the previous two strobes, y1 and y2 are the outputs of the previous two strobes, and the coefficients are signed 16-bit values with 14 fraction bits.
- R4: `pred_vld` is high for exactly the one cycle after each cycle in which `sample_stb` is high, and is low in every other cycle.
- R5: Without a sample strobe, `pred_now` and the filter history do not change, whatever happens on `seq_on`, `avg_level` or the coefficient inputs.
- R6: The result of R3 is saturated to the signed 16-bit range -32768..32767 before it is output and before it is stored as history.
- R7: `pred_held` takes the value `pred_now` had before the edge at which `period_stb` is high, and otherwise keeps its value. When both strobes occur in the same cycle, it captures the prediction from before that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sample_stb | input | 1 | Fast sample strobe, one cycle per sample |
| seq_on | input | 1 | Sustain-phase flag: 1 means a discharge phase is active |
| avg_level | input | 8 | Average picture level, unsigned |
| coef_b0 | input | 16 | Feed coefficient for the current input, signed Q2.14 |
| coef_b1 | input | 16 | Feed coefficient for the input one sample back, signed Q2.14 |
| coef_b2 | input | 16 | Feed coefficient for the input two samples back, signed Q2.14 |
| coef_a1 | input | 16 | Feedback coefficient for the output one sample back, signed Q2.14 |
| coef_a2 | input | 16 | Feedback coefficient for the output two samples back, signed Q2.14 |
| period_stb | input | 1 | Switching-period strobe that latches the prediction |
| pred_now | output | 16 | Predicted load current, updated each sample, signed |
| pred_vld | output | 1 | High for the one cycle after each sample strobe |
| pred_held | output | 16 | Prediction latched once per switching period, signed |

## Verification
The hardest situation to reach from the ports is output saturation. A stable low-pass filter driven with 8-bit inputs settles far below the 16-bit limits. The stimulus therefore programs a pure integrator (a1 equal to -1.0) with a large positive, then a large negative, feed coefficient. It then strobes full-scale samples until the sum reaches each rail, and keeps strobing there to show that the stored history stays clipped. A second hard case is a sample strobe and a period strobe in the same cycle. The stimulus creates it by driving both in one cycle and checks that the latched value is the prediction from before that sample.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  // Tap ordering of the filter: three feed taps, then two feedback taps
  localparam int NTAPS = 5;
  localparam int TAP_X0 = 0;
  localparam int TAP_X1 = 1;
  localparam int TAP_X2 = 2;
  localparam int TAP_Y1 = 3;
  localparam int TAP_Y2 = 4;

  // Feedback taps are subtracted in the accumulator
  function automatic bit tap_is_feedback(input int idx);
    return (idx == TAP_Y1) || (idx == TAP_Y2);
  endfunction
endpackage

// File: rtl/vlp_gate.sv
module vlp_gate #(
  parameter int LVL_W = 8
) (
  input  logic             seq_on,
  input  logic [LVL_W-1:0] avg_level,
  output logic [LVL_W-1:0] dis_est
);
  // Discharge estimate: level passes only during a sustain phase
  always_comb begin
    dis_est = avg_level & {LVL_W{seq_on}};
  end
endmodule

// File: rtl/vlp_biquad.sv
module vlp_biquad
  import vlp_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int OUT_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_en,
  input  logic [LVL_W-1:0]         x_in,
  input  logic signed [COEF_W-1:0] b0,
  input  logic signed [COEF_W-1:0] b1,
  input  logic signed [COEF_W-1:0] b2,
  input  logic signed [COEF_W-1:0] a1,
  input  logic signed [COEF_W-1:0] a2,
  output logic signed [OUT_W-1:0]  y_out,
  output logic                     y_vld
);
  localparam int XW    = LVL_W + 1;
  localparam int SW    = (XW > OUT_W) ? XW : OUT_W;
  localparam int PW    = COEF_W + SW;
  localparam int ACC_W = PW + 3;
  localparam longint YMAX_L = (longint'(1) << (OUT_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] YMAX = ACC_W'(YMAX_L);
  localparam logic signed [ACC_W-1:0] YMIN = ACC_W'(-YMAX_L - 1);

  // History registers
  logic [LVL_W-1:0]        x1_q, x2_q, x1_d, x2_d;
  logic signed [OUT_W-1:0] y1_q, y2_q, y1_d, y2_d;
  logic                    vld_q, vld_d;

  // Tap samples, coefficients and products
  logic signed [SW-1:0]     tap_s [NTAPS];
  logic signed [COEF_W-1:0] tap_c [NTAPS];
  logic signed [PW-1:0]     prod  [NTAPS];
  logic signed [ACC_W-1:0]  term  [NTAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;
  logic signed [OUT_W-1:0]  y_sat;

  always_comb begin
    tap_s[TAP_X0] = SW'($signed({1'b0, x_in}));
    tap_s[TAP_X1] = SW'($signed({1'b0, x1_q}));
    tap_s[TAP_X2] = SW'($signed({1'b0, x2_q}));
    tap_s[TAP_Y1] = SW'(y1_q);
    tap_s[TAP_Y2] = SW'(y2_q);
    tap_c[TAP_X0] = b0;
    tap_c[TAP_X1] = b1;
    tap_c[TAP_X2] = b2;
    tap_c[TAP_Y1] = a1;
    tap_c[TAP_Y2] = a2;
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    always_comb begin
      prod[i] = PW'(tap_s[i]) * PW'(tap_c[i]);
    end
    if (tap_is_feedback(i)) begin : g_sub
      always_comb term[i] = -ACC_W'(prod[i]);
    end else begin : g_add
      always_comb term[i] = ACC_W'(prod[i]);
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc = acc + term[k];
    end
    scaled = acc >>> COEF_FRAC;
    if (scaled > YMAX) begin
      y_sat = OUT_W'(YMAX);
    end else if (scaled < YMIN) begin
      y_sat = OUT_W'(YMIN);
    end else begin
      y_sat = OUT_W'(scaled);
    end
  end

  // Next-state logic
  always_comb begin
    x1_d  = x1_q;
    x2_d  = x2_q;
    y1_d  = y1_q;
    y2_d  = y2_q;
    vld_d = smp_en;
    if (smp_en) begin
      x1_d = x_in;
      x2_d = x1_q;
      y1_d = y_sat;
      y2_d = y1_q;
    end
  end

  // Register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q  <= '0;
      x2_q  <= '0;
      y1_q  <= '0;
      y2_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      x1_q  <= x1_d;
      x2_q  <= x2_d;
      y1_q  <= y1_d;
      y2_q  <= y2_d;
      vld_q <= vld_d;
    end
  end

  assign y_out = y1_q;
  assign y_vld = vld_q;
endmodule

// File: rtl/vlp_hold.sv
module vlp_hold #(
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold_en,
  input  logic signed [OUT_W-1:0] pred_in,
  output logic signed [OUT_W-1:0] pred_hold
);
  logic signed [OUT_W-1:0] held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (hold_en) begin
      held_d = pred_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else begin
      held_q <= held_d;
    end
  end

  assign pred_hold = held_q;
endmodule

// File: rtl/vid_load_predictor.sv
module vid_load_predictor #(
  parameter int LVL_W     = 8,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int OUT_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_stb,
  input  logic                     seq_on,
  input  logic [LVL_W-1:0]         avg_level,
  input  logic signed [COEF_W-1:0] coef_b0,
  input  logic signed [COEF_W-1:0] coef_b1,
  input  logic signed [COEF_W-1:0] coef_b2,
  input  logic signed [COEF_W-1:0] coef_a1,
  input  logic signed [COEF_W-1:0] coef_a2,
  input  logic                     period_stb,
  output logic signed [OUT_W-1:0]  pred_now,
  output logic                     pred_vld,
  output logic signed [OUT_W-1:0]  pred_held
);
  logic [LVL_W-1:0] dis_est;

  vlp_gate #(.LVL_W(LVL_W)) u_gate (
    .seq_on    (seq_on),
    .avg_level (avg_level),
    .dis_est   (dis_est)
  );

  vlp_biquad #(
    .LVL_W     (LVL_W),
    .COEF_W    (COEF_W),
    .COEF_FRAC (COEF_FRAC),
    .OUT_W     (OUT_W)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (sample_stb),
    .x_in   (dis_est),
    .b0     (coef_b0),
    .b1     (coef_b1),
    .b2     (coef_b2),
    .a1     (coef_a1),
    .a2     (coef_a2),
    .y_out  (pred_now),
    .y_vld  (pred_vld)
  );

  vlp_hold #(.OUT_W(OUT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_en   (period_stb),
    .pred_in   (pred_now),
    .pred_hold (pred_held)
  );
endmodule

// File: rtl/vlp_checker.sv
module vlp_checker #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_stb,
  input logic                    period_stb,
  input logic signed [OUT_W-1:0] pred_now,
  input logic                    pred_vld,
  input logic signed [OUT_W-1:0] pred_held
);
  // R1: outputs are zero whenever reset is asserted at a clock edge
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (pred_now == '0 && pred_held == '0 && !pred_vld));

  // R4: valid follows every sample strobe
  a_r4_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> pred_vld);

  // R4: valid only after a sample strobe
  a_r4_vld_only_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> !pred_vld);

  // R5: prediction steady without a sample strobe
  a_r5_pred_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(pred_now));

  // R7: latched prediction steady without a period strobe
  a_r7_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !period_stb |=> $stable(pred_held));

  // R7: latched value is the prediction from before the period edge
  a_r7_held_capture: assert property (@(posedge clk) disable iff (!rst_n)
    period_stb |=> (pred_held == $past(pred_now)));
endmodule

bind vid_load_predictor vlp_checker #(.OUT_W(OUT_W)) u_vlp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .period_stb (period_stb),
  .pred_now   (pred_now),
  .pred_vld   (pred_vld),
  .pred_held  (pred_held)
);

// File: tb/vid_load_predictor_bench.sv
module vid_load_predictor_bench;
  logic              clk;
  logic              rst_n;
  logic              sample_stb;
  logic              seq_on;
  logic [7:0]        avg_level;
  logic signed [15:0] cb0, cb1, cb2, ca1, ca2;
  logic              period_stb;
  logic signed [15:0] pred_now;
  logic              pred_vld;
  logic signed [15:0] pred_held;

  int checks;
  int failures;
  int mx1, mx2, my1, my2;

  vid_load_predictor u_vid_load_predictor (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .seq_on     (seq_on),
    .avg_level  (avg_level),
    .coef_b0    (cb0),
    .coef_b1    (cb1),
    .coef_b2    (cb2),
    .coef_a1    (ca1),
    .coef_a2    (ca2),
    .period_stb (period_stb),
    .pred_now   (pred_now),
    .pred_vld   (pred_vld),
    .pred_held  (pred_held)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model of the filter from the requirement text (R2, R3, R6)
  function automatic int model_step(input bit s, input int lvl);
    longint x, acc, y;
    x = s ? lvl : 0;
    acc = longint'(cb0) * x + longint'(cb1) * mx1 + longint'(cb2) * mx2
        - longint'(ca1) * my1 - longint'(ca2) * my2;
    y = acc >>> 14;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    mx2 = mx1; mx1 = int'(x);
    my2 = my1; my1 = int'(y);
    return int'(y);
  endfunction

  task automatic set_coefs(input int b0, input int b1, input int b2, input int a1, input int a2);
    @(negedge clk);
    cb0 = 16'(b0); cb1 = 16'(b1); cb2 = 16'(b2); ca1 = 16'(a1); ca2 = 16'(a2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
  endtask

  // One sample strobe; returns at the negedge after the update edge
  task automatic do_sample(input bit s, input int lvl, output int expv);
    @(negedge clk);
    sample_stb = 1'b1; seq_on = s; avg_level = 8'(lvl);
    expv = model_step(s, lvl);
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic t_reset_state();
    int e;
    set_coefs(16384, 0, 0, 0, 0);
    do_sample(1'b1, 99, e);
    @(negedge clk); period_stb = 1'b1;
    @(negedge clk); period_stb = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 pred_now in reset", pred_now, 0);
    check("R1 pred_held in reset", pred_held, 0);
    check("R1 pred_vld in reset", pred_vld, 0);
    rst_n = 1'b1;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
  endtask

  task automatic t_gate();
    int e;
    do_reset();
    set_coefs(16384, 0, 0, 0, 0);
    do_sample(1'b1, 200, e); check("R2 seq=1 lvl=200", pred_now, 200);
    do_sample(1'b0, 200, e); check("R2 seq=0 lvl=200", pred_now, 0);
    do_sample(1'b1, 255, e); check("R2 seq=1 lvl=255", pred_now, 255);
    do_sample(1'b1, 0, e);   check("R2 seq=1 lvl=0", pred_now, 0);
    do_sample(1'b0, 255, e); check("R2 seq=0 lvl=255", pred_now, 0);
  endtask

  task automatic t_valid();
    int e;
    do_reset();
    @(negedge clk);
    check("R4 vld idle", pred_vld, 0);
    do_sample(1'b1, 10, e);
    check("R4 vld after strobe", pred_vld, 1);
    @(negedge clk);
    check("R4 vld one cycle only", pred_vld, 0);
  endtask

  task automatic t_no_strobe();
    int e;
    do_reset();
    set_coefs(16384, 8192, 4096, 0, 0);
    do_sample(1'b1, 120, e);
    check("R3 pre value", pred_now, e);
    set_coefs(-20000, 3000, 3000, -16384, 100);
    seq_on = 1'b1; avg_level = 8'd250;
    repeat (6) @(negedge clk);
    check("R5 output steady without strobe", pred_now, e);
    // history untouched: next sample with original coefficients follows the model
    set_coefs(16384, 8192, 4096, 0, 0);
    do_sample(1'b1, 40, e);
    check("R5 history untouched", pred_now, e);
  endtask

  task automatic t_filter();
    int e;
    do_reset();
    set_coefs(1024, 2048, 1024, -26214, 11469);
    for (int n = 0; n < 80; n++) begin
      do_sample(((n / 5) % 2) == 0, (n * 37 + 11) % 256, e);
      check("R3 biquad response", pred_now, e);
    end
  endtask

  task automatic t_sat();
    int e;
    do_reset();
    set_coefs(32767, 0, 0, -16384, 0);
    for (int n = 0; n < 80; n++) begin
      do_sample(1'b1, 255, e);
    end
    check("R6 positive rail", pred_now, 32767);
    check("R6 positive model", pred_now, e);
    do_reset();
    set_coefs(-32768, 0, 0, -16384, 0);
    for (int n = 0; n < 80; n++) begin
      do_sample(1'b1, 255, e);
    end
    check("R6 negative rail", pred_now, -32768);
    // history clipped: small positive input lifts from the rail by the exact step
    set_coefs(16384, 0, 0, -16384, 0);
    do_sample(1'b1, 5, e);
    check("R6 clipped history", pred_now, -32763);
  endtask

  task automatic t_hold();
    int e, first;
    do_reset();
    set_coefs(16384, 0, 0, 0, 0);
    do_sample(1'b1, 77, e);
    first = e;
    @(negedge clk); period_stb = 1'b1;
    @(negedge clk); period_stb = 1'b0;
    check("R7 capture", pred_held, first);
    do_sample(1'b1, 150, e);
    do_sample(1'b1, 180, e);
    check("R7 held steady", pred_held, first);
    // both strobes together: latch the value from before this sample
    @(negedge clk);
    sample_stb = 1'b1; period_stb = 1'b1; seq_on = 1'b1; avg_level = 8'd33;
    e = model_step(1'b1, 33);
    @(negedge clk);
    sample_stb = 1'b0; period_stb = 1'b0;
    check("R7 simultaneous strobes held", pred_held, 180);
    check("R7 simultaneous strobes new", pred_now, 33);
  endtask

  task automatic t_reset_mid();
    int e;
    do_reset();
    set_coefs(16384, 16384, 0, 0, 0);
    do_sample(1'b1, 90, e);
    do_sample(1'b1, 60, e);
    do_reset();
    set_coefs(0, 16384, 0, 0, 0);
    do_sample(1'b1, 70, e);
    check("R1 history cleared", pred_now, 0);
    do_sample(1'b1, 10, e);
    check("R1 first post-reset input delayed", pred_now, 70);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; sample_stb = 1'b0; period_stb = 1'b0;
    seq_on = 1'b0; avg_level = '0;
    cb0 = '0; cb1 = '0; cb2 = '0; ca1 = '0; ca2 = '0;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    repeat (3) @(negedge clk);
    check("R1 reset state now", pred_now, 0);
    check("R1 reset state vld", pred_vld, 0);
    rst_n = 1'b1;
    t_reset_state();
    t_gate();
    t_valid();
    t_no_strobe();
    t_filter();
    t_sat();
    t_hold();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule